// File: doc/BRIEF.md
# Dual-network 4x4 deflection routing core

This block is the four-by-four switching core of an element that belongs to two self-routing networks at once: one built on a shuffle wiring, the other on an unshuffle wiring. Every cell carries a routing tag made of an address of two-bit pairs, a distance, and a copy of the address it started with. The distance names the pair that steers the cell at this element. Within a pair, the upper bit picks the shuffle side (1) or the unshuffle side (0), and the lower bit picks one of that side's two links. Interstage outlet p (0 to 3) is the outlet whose pair value equals p.

In each cycle the core takes up to four cells. A cell with distance above zero asks for the interstage outlet named by its current pair. A cell at distance zero asks for one of two local outlets toward the output queues. When cells contend for one interstage outlet, the cell nearer its destination wins. Every cell that loses is deflected onto an interstage outlet that no winner took. The core then rewrites the loser's tag so that the following stages bring it back to its row. The distance goes up by one and the pair at the new distance becomes a compensating pair. A cell that loses while already at the largest distance has its tag restored from the original copy. All outputs are registered, so the latency is one cycle.

The number of address pairs is set by a parameter `N`, which is the network's stage count. `N` must be 2 or more. The current address holds N+1 pairs, numbered 0 to N. Pair j sits at bits 2j+1:2j. The distance field can therefore hold the value N. The row input carries the N-1 bits of this element's row number. These bits supply the lower bit of the compensating pair.

Top module: `xsw_core`

## Requirements
- R1: While reset is held, no interstage or local outlet is valid, and this stays true on the first cycle after reset is released.
- R2: Each valid input cell appears on exactly one output, either an interstage outlet or a local outlet, one cycle after it is presented. The original-address copy travels with the cell unchanged.
- R3: A cell with distance d>0 that has no contender goes to the interstage outlet whose number equals its pair d. It leaves with distance d-1, and its address and original copy are unchanged.
- R4: A cell with distance 0 goes to local outlet b, where b is bit 0 of its address (the lower bit of pair 0). That local outlet presents the cell's original-address copy.
- R5: When several cells ask for the same interstage outlet, the cell with the smallest distance wins. On equal distances, the lowest input index wins.
- R6: When two distance-0 cells ask for the same local outlet, the lower input index wins. The other cell is deflected onto an interstage outlet.
- R7: Losing cells are placed in ascending input order. Each takes the lowest-numbered interstage outlet not already used by a winner or by an earlier loser.
- R8: A loser with distance k<N leaves with distance k+1. Its pair k+1 is replaced by a compensating pair and all other pairs stay as they were. The compensating pair depends on where the loser was placed. For a loser placed on outlet 2 or 3 (shuffle side), the pair is {0, row bit N-2}. For a loser placed on outlet 0 or 1 (unshuffle side), the pair is {1, row bit 0}.
- R9: A loser with distance N leaves with distance N-1. Its address is restored to its original copy in pairs 0 to N-1, and pair N is set to zero.
- R10: Address pairs above a cell's current distance have no effect on where the cell goes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 4 | Valid flag per input cell |
| in_addr | input | 4*2*(N+1) | Current address per input, N+1 pairs each |
| in_dist | input | 4*clog2(N+1) | Distance per input |
| in_orig | input | 4*2*N | Original-address copy per input |
| row_id | input | N-1 | Row number of this element |
| out_vld | output | 4 | Valid flag per interstage outlet |
| out_addr | output | 4*2*(N+1) | Rewritten address per interstage outlet |
| out_dist | output | 4*clog2(N+1) | New distance per interstage outlet |
| out_orig | output | 4*2*N | Original copy per interstage outlet |
| loc_vld | output | 2 | Valid flag per local outlet |
| loc_orig | output | 2*2*N | Original copy of the cell on each local outlet |

## Verification
The hardest case to reach is the tag reset. It needs a cell already at the largest distance, which a correct network only produces after earlier deflections, and that cell must lose an outlet in the same cycle. The stimulus sets the distance field to N directly and adds a nearer contender for the same outlet. A dense random sweep over four cells, every distance from 0 to N, random addresses and random row numbers also crowds all four inputs onto one or two outlets. That sweep exercises the loser ordering and both compensating-pair forms against an arithmetic expectation.

// File: rtl/xsw_core.sv
module xsw_core #(
  parameter int N = 3,
  localparam int AW = 2 * (N + 1),
  localparam int DW = $clog2(N + 1),
  localparam int OW = 2 * N,
  localparam int RW = N - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      in_vld,
  input  logic [4*AW-1:0] in_addr,
  input  logic [4*DW-1:0] in_dist,
  input  logic [4*OW-1:0] in_orig,
  input  logic [RW-1:0]   row_id,
  output logic [3:0]      out_vld,
  output logic [4*AW-1:0] out_addr,
  output logic [4*DW-1:0] out_dist,
  output logic [4*OW-1:0] out_orig,
  output logic [1:0]      loc_vld,
  output logic [2*OW-1:0] loc_orig
);

  logic [AW-1:0] a  [4];
  logic [DW-1:0] d  [4];
  logic [OW-1:0] o  [4];
  logic [1:0]    rp [4];
  logic [3:0]    rem, loc, win;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      a[i]   = in_addr[i*AW +: AW];
      d[i]   = in_dist[i*DW +: DW];
      o[i]   = in_orig[i*OW +: OW];
      rp[i]  = a[i][2*int'(d[i]) +: 2];
      rem[i] = in_vld[i] && (d[i] != '0);
      loc[i] = in_vld[i] && (d[i] == '0);
    end
    for (int i = 0; i < 4; i++) begin
      win[i] = rem[i] | loc[i];
      for (int j = 0; j < 4; j++) begin
        if (j != i) begin
          if (rem[i] && rem[j] && rp[j] == rp[i] &&
              (d[j] < d[i] || (d[j] == d[i] && j < i)))
            win[i] = 1'b0;
          if (loc[i] && loc[j] && rp[j][0] == rp[i][0] && j < i)
            win[i] = 1'b0;
        end
      end
    end
  end

  logic [3:0]    nv, busy;
  logic [1:0]    nlv;
  logic [AW-1:0] na  [4];
  logic [DW-1:0] nd  [4];
  logic [OW-1:0] no  [4];
  logic [OW-1:0] nlo [2];
  logic [1:0]    fsel;
  logic          fnd;

  always_comb begin
    nv   = '0;
    busy = '0;
    nlv  = '0;
    fsel = '0;
    fnd  = 1'b0;
    for (int p = 0; p < 4; p++) begin
      na[p] = '0;
      nd[p] = '0;
      no[p] = '0;
    end
    nlo[0] = '0;
    nlo[1] = '0;
    for (int i = 0; i < 4; i++) begin
      if (win[i] && rem[i]) begin
        nv[rp[i]]   = 1'b1;
        busy[rp[i]] = 1'b1;
        na[rp[i]]   = a[i];
        nd[rp[i]]   = d[i] - 1'b1;
        no[rp[i]]   = o[i];
      end
      if (win[i] && loc[i]) begin
        nlv[rp[i][0]] = 1'b1;
        nlo[rp[i][0]] = o[i];
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (in_vld[i] && !win[i]) begin
        fnd  = 1'b0;
        fsel = '0;
        for (int p = 0; p < 4; p++) begin
          if (!fnd && !busy[p]) begin
            fnd  = 1'b1;
            fsel = 2'(p);
          end
        end
        busy[fsel] = 1'b1;
        nv[fsel]   = 1'b1;
        no[fsel]   = o[i];
        if (d[i] == DW'(N)) begin
          na[fsel] = {2'b00, o[i]};
          nd[fsel] = DW'(N - 1);
        end else begin
          na[fsel] = a[i];
          na[fsel][2*(int'(d[i])+1) +: 2] =
            {~fsel[1], fsel[1] ? row_id[RW-1] : row_id[0]};
          nd[fsel] = d[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= '0;
      loc_vld  <= '0;
      out_addr <= '0;
      out_dist <= '0;
      out_orig <= '0;
      loc_orig <= '0;
    end else begin
      out_vld <= nv;
      loc_vld <= nlv;
      for (int p = 0; p < 4; p++) begin
        out_addr[p*AW +: AW] <= na[p];
        out_dist[p*DW +: DW] <= nd[p];
        out_orig[p*OW +: OW] <= no[p];
      end
      loc_orig[0 +: OW]  <= nlo[0];
      loc_orig[OW +: OW] <= nlo[1];
    end
  end

endmodule

// File: rtl/xsw_core_chk.sv
module xsw_core_chk #(
  parameter int N = 3,
  localparam int AW = 2 * (N + 1),
  localparam int DW = $clog2(N + 1),
  localparam int OW = 2 * N,
  localparam int RW = N - 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      in_vld,
  input logic [4*AW-1:0] in_addr,
  input logic [4*DW-1:0] in_dist,
  input logic [4*OW-1:0] in_orig,
  input logic [RW-1:0]   row_id,
  input logic [3:0]      out_vld,
  input logic [4*AW-1:0] out_addr,
  input logic [4*DW-1:0] out_dist,
  input logic [4*OW-1:0] out_orig,
  input logic [1:0]      loc_vld,
  input logic [2*OW-1:0] loc_orig
);

  logic [DW-1:0] d0, d1;
  logic [1:0]    pr0;
  assign d0  = in_dist[0 +: DW];
  assign d1  = in_dist[DW +: DW];
  assign pr0 = in_addr[2*int'(d0) +: 2];

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (out_vld == 4'b0 && loc_vld == 2'b0));

  p_conserve_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(out_vld) + $countones(loc_vld)) == $past($countones(in_vld)));

  p_lone_remote_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld == 4'b0001 && d0 != '0) |=> (out_vld == (4'b0001 << $past(pr0)) && loc_vld == 2'b0));

  p_lone_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld == 4'b0001 && d0 == '0) |=>
      (out_vld == 4'b0 && loc_vld == ($past(in_addr[0]) ? 2'b10 : 2'b01)));

  p_local_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld == 4'b0011 && d0 == '0 && d1 == '0 && in_addr[0] == in_addr[AW]) |=>
      ($countones(loc_vld) == 1 && $countones(out_vld) == 1));

endmodule

bind xsw_core xsw_core_chk #(.N(N)) u_chk (.*);

// File: tb/xsw_core_tb.sv
module xsw_core_tb;
  localparam int N  = 3;
  localparam int AW = 2 * (N + 1);
  localparam int DW = $clog2(N + 1);
  localparam int OW = 2 * N;
  localparam int RW = N - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]      in_vld = '0;
  logic [4*AW-1:0] in_addr = '0;
  logic [4*DW-1:0] in_dist = '0;
  logic [4*OW-1:0] in_orig = '0;
  logic [RW-1:0]   row_id = '0;
  logic [3:0]      out_vld;
  logic [4*AW-1:0] out_addr;
  logic [4*DW-1:0] out_dist;
  logic [4*OW-1:0] out_orig;
  logic [1:0]      loc_vld;
  logic [2*OW-1:0] loc_orig;

  always #2 clk = ~clk;

  xsw_core #(.N(N)) u_dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [3:0] sv;
  int s_a[4], s_d[4], s_o[4], s_row;
  bit e_vld[4], e_lv[2];
  int e_a[4], e_d[4], e_o[4], e_lo[2];

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model();
    bit used[4], placed[4];
    int best, f, comp, sh;
    for (int p = 0; p < 4; p++) begin
      used[p] = 0; placed[p] = 0; e_vld[p] = 0; e_a[p] = 0; e_d[p] = 0; e_o[p] = 0;
    end
    e_lv[0] = 0; e_lv[1] = 0; e_lo[0] = 0; e_lo[1] = 0;
    for (int p = 0; p < 4; p++) begin
      best = -1;
      for (int i = 0; i < 4; i++)
        if (sv[i] && s_d[i] > 0 && ((s_a[i] >> (2*s_d[i])) & 3) == p)
          if (best < 0 || s_d[i] < s_d[best]) best = i;
      if (best >= 0) begin
        placed[best] = 1; used[p] = 1; e_vld[p] = 1;
        e_a[p] = s_a[best]; e_d[p] = s_d[best] - 1; e_o[p] = s_o[best];
      end
    end
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++)
        if (sv[i] && s_d[i] == 0 && (s_a[i] & 1) == b && !e_lv[b]) begin
          e_lv[b] = 1; e_lo[b] = s_o[i]; placed[i] = 1;
        end
    for (int i = 0; i < 4; i++)
      if (sv[i] && !placed[i]) begin
        f = 0;
        while (used[f]) f++;
        used[f] = 1; e_vld[f] = 1; e_o[f] = s_o[i];
        if (s_d[i] == N) begin
          e_a[f] = s_o[i]; e_d[f] = N - 1;
        end else begin
          comp = (f >= 2) ? ((s_row >> (RW-1)) & 1) : (2 | (s_row & 1));
          sh = 2 * (s_d[i] + 1);
          e_a[f] = ((s_a[i] & ~(3 << sh)) | (comp << sh)) & ((1 << AW) - 1);
          e_d[f] = s_d[i] + 1;
        end
      end
  endtask

  task automatic apply(string tag);
    in_vld = sv;
    row_id = RW'(s_row);
    for (int i = 0; i < 4; i++) begin
      in_addr[i*AW +: AW] = AW'(s_a[i]);
      in_dist[i*DW +: DW] = DW'(s_d[i]);
      in_orig[i*OW +: OW] = OW'(s_o[i]);
    end
    model();
    @(negedge clk);
    chk({tag, " outlet valid"}, longint'(out_vld),
        longint'({e_vld[3], e_vld[2], e_vld[1], e_vld[0]}));
    chk({tag, " local valid"}, longint'(loc_vld), longint'({e_lv[1], e_lv[0]}));
    for (int p = 0; p < 4; p++)
      if (e_vld[p] && out_vld[p])
        chk({tag, " outlet tag"},
            longint'({out_addr[p*AW +: AW], out_dist[p*DW +: DW], out_orig[p*OW +: OW]}),
            longint'({AW'(e_a[p]), DW'(e_d[p]), OW'(e_o[p])}));
    for (int b = 0; b < 2; b++)
      if (e_lv[b] && loc_vld[b])
        chk({tag, " local orig"}, longint'(loc_orig[b*OW +: OW]), longint'(e_lo[b]));
  endtask

  task automatic clear();
    sv = '0; s_row = 0;
    for (int i = 0; i < 4; i++) begin s_a[i] = 0; s_d[i] = 0; s_o[i] = i + 1; end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    in_vld = 4'b1111;
    repeat (3) @(negedge clk);
    chk("R1 reset outlet valid", longint'(out_vld), 0);
    chk("R1 reset local valid", longint'(loc_vld), 0);
    in_vld = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", longint'({out_vld, loc_vld}), 0);

    clear(); sv = 4'b0001; s_d[0] = 2; s_a[0] = 'h30; s_o[0] = 'h15;
    apply("R3");
    chk("R3 outlet", longint'(out_vld), 'b1000);
    chk("R3 distance", longint'(out_dist[3*DW +: DW]), 1);

    clear(); sv = 4'b0010; s_d[1] = 0; s_a[1] = 'h01; s_o[1] = 'h2C;
    apply("R4");
    chk("R4 local orig", longint'(loc_orig[OW +: OW]), 'h2C);

    clear(); sv = 4'b0101; s_row = 1;
    s_d[0] = 2; s_a[0] = 'h10; s_d[2] = 1; s_a[2] = 'h04;
    apply("R5 distance");
    chk("R5 winner dist", longint'(out_dist[DW +: DW]), 0);
    chk("R8 unshuffle comp addr", longint'(out_addr[0 +: AW]), 'hD0);
    chk("R8 unshuffle comp dist", longint'(out_dist[0 +: DW]), 3);

    clear(); sv = 4'b1010; s_row = 0;
    s_d[1] = 1; s_a[1] = 'h08; s_d[3] = 1; s_a[3] = 'h08;
    apply("R5 tie");
    chk("R5 tie winner orig", longint'(out_orig[2*OW +: OW]), 2);

    clear(); sv = 4'b0101; s_a[0] = 'h00; s_a[2] = 'h02;
    apply("R6");
    chk("R6 winner local", longint'(loc_orig[0 +: OW]), 1);
    chk("R6 loser dist", longint'(out_dist[0 +: DW]), 1);

    clear(); sv = 4'b1111;
    for (int i = 0; i < 4; i++) begin s_d[i] = 1; s_a[i] = 'h00; end
    apply("R7");
    chk("R7 order", longint'(out_orig), longint'({6'd4, 6'd3, 6'd2, 6'd1}));

    clear(); sv = 4'b0011; s_d[0] = 3; s_a[0] = 'h80; s_o[0] = 'h2A;
    s_d[1] = 1; s_a[1] = 'h08;
    apply("R9");
    chk("R9 restored addr", longint'(out_addr[0 +: AW]), 'h2A);
    chk("R9 restored dist", longint'(out_dist[0 +: DW]), 2);

    clear(); sv = 4'b0111; s_row = 2;
    s_d[0] = 1; s_a[0] = 'h00; s_d[1] = 1; s_a[1] = 'h04; s_d[2] = 2; s_a[2] = 'h00;
    apply("R8 shuffle");
    chk("R8 shuffle comp addr", longint'(out_addr[2*AW +: AW]), 'h40);

    clear(); sv = 4'b0001; s_d[0] = 1; s_a[0] = 'h0C;
    apply("R10 clean");
    clear(); sv = 4'b0001; s_d[0] = 1; s_a[0] = 'hFC;
    apply("R10 upper pairs");
    chk("R10 outlet", longint'(out_vld), 'b1000);

    for (int t = 0; t < 4000; t++) begin
      sv = 4'($urandom);
      s_row = int'($urandom % 4);
      for (int i = 0; i < 4; i++) begin
        s_d[i] = int'($urandom % (N + 1));
        s_a[i] = int'($urandom % (1 << AW));
        s_o[i] = int'($urandom % (1 << OW));
      end
      apply("R2 sweep");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule